// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synchronous memory whose commands (read, write or deselect) may follow one another on every enabled clock edge, in any order, with no idle cycle for bus turnaround. Every command input is registered on the rising edge. Read data leaves an output register one edge after the read command. Write data and its byte enables are sampled two edges after the write command. The bidirectional data bus is split into an input bus, an output bus and an output-drive flag.

A global clock enable freezes the whole pipeline. A sleep input parks the block with its contents intact. A combinational output enable gates the drive flag. When the load input is high, the previous access continues at the next address inside an aligned group of four words. A read issued on the cycle after a write to the same address sees the new data through a bypass path.

Top module: `pipelined_sram`

## Requirements
- R1: While `clkEnN` is high, rising edges have no effect. Pipeline, address and output registers all keep their values, and a command presented then is never performed.
- R2: A new access is accepted only when, at the edge, `clkEnN` is low, `ldN` is low and all three selects are active (`selAN` low, `selB` high, `selCN` low). With `ldN` low and any select inactive, the command is a deselect.
- R3: An accepted access with `weN` high is a read. After the next enabled edge, `dqOut` holds the addressed word and `dqOe` is high while `oeN` is low.
- R4: A command may be accepted on every consecutive enabled edge, mixing reads and writes, with every read returning the correct word.
- R5: A deselect is pipelined. Data from a read accepted one edge earlier is still driven after the deselect edge, and `dqOe` goes low only after the following edge.
- R6: For a write accepted at edge E, `dqIn` and `byteWeN` are sampled at enabled edge E+2. Between edges E+1 and E+2, `dqOe` is low whatever `oeN` is.
- R7: `byteWeN[i]` low writes lane i (bits `i*LANE_W` up to `i*LANE_W+LANE_W-1`). Lanes whose enable is high keep their old contents.
- R8: `oeN` acts combinationally. Raising it drops `dqOe` without a clock edge, and lowering it restores the drive.
- R9: While `sleep` is high, `dqOe` is low, commands are ignored and stored words are preserved.
- R10: A read accepted on the edge right after a write to the same address returns the newly written lanes, merged with the old contents of the unwritten lanes.
- R11: With `ldN` high at an enabled edge, the previous access type repeats. The low two address bits increment modulo 4, the upper bits stay the same, and the selects and `weN` are ignored. After a deselect, the block stays deselected.
- R12: After reset, `dqOe` is low and no access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset of the pipeline |
| clkEnN | input | 1 | Active-low clock qualifier |
| selAN | input | 1 | Select, active low |
| selB | input | 1 | Select, active high |
| selCN | input | 1 | Select, active low |
| ldN | input | 1 | Low: load new command; high: advance previous access |
| weN | input | 1 | Low: write, high: read |
| byteWeN | input | LANES | Active-low lane write enables, sampled with write data |
| addr | input | AW | Word address |
| dqIn | input | LANES*LANE_W | Write data |
| oeN | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Active-high low-activity mode |
| dqOut | output | LANES*LANE_W | Registered read data |
| dqOe | output | 1 | High when the data bus is driven |

## Verification
The assertions take `rstN` to be applied synchronously with the pipeline idle afterwards. They also take `addr` to be at least two bits wide, so that the advance wrap is meaningful. The bench changes every input one nanosecond after a rising edge, never near an edge. During a sleep or a clock-hold interval it holds `sleep` or `clkEnN` constant across whole cycles. It presents write data on exactly the second enabled edge after each write command and keeps `byteWeN` all high on every other edge.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
  // Strobes from the command pipeline to the storage datapath
  typedef struct packed {
    logic en;        // edge is effective (clock enabled, not asleep)
    logic rdLoad;    // stage-1 holds a read: load output register
    logic wrCommit;  // stage-2 holds a write: commit lanes this edge
  } sram_strobe_t;
endpackage

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clkEnN,
  input  logic          sleep,
  input  logic          selAN,
  input  logic          selB,
  input  logic          selCN,
  input  logic          ldN,
  input  logic          weN,
  input  logic [AW-1:0] addr,
  output sram_strobe_t  stb,
  output logic [AW-1:0] rdAddr,
  output logic [AW-1:0] wrAddr
);
  logic          s1Valid, s1Write;
  logic [AW-1:0] s1Addr;
  logic          s2Valid, s2Write;
  logic [AW-1:0] s2Addr;
  logic          allSel;
  logic          edgeEn;

  assign allSel = !selAN && selB && !selCN;
  assign edgeEn = !clkEnN && !sleep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Write <= 1'b0;
      s1Addr  <= '0;
      s2Valid <= 1'b0;
      s2Write <= 1'b0;
      s2Addr  <= '0;
    end else if (edgeEn) begin
      s2Valid <= s1Valid;
      s2Write <= s1Write;
      s2Addr  <= s1Addr;
      if (!ldN) begin
        s1Valid <= allSel;
        s1Write <= !weN;
        s1Addr  <= addr;
      end else begin
        s1Addr  <= {s1Addr[AW-1:2], s1Addr[1:0] + 2'd1};
      end
    end
  end

  always_comb begin
    stb.en       = edgeEn;
    stb.rdLoad   = s1Valid && !s1Write;
    stb.wrCommit = s2Valid && s2Write;
  end

  assign rdAddr = s1Addr;
  assign wrAddr = s2Addr;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnN || sleep) |=> ($stable(s1Valid) && $stable(s1Addr) && $stable(s2Valid) && $stable(s2Addr))); // R1 R9
  AST_DESELECT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (edgeEn && !ldN && !allSel) |=> !s1Valid); // R2
  AST_READ_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (edgeEn && !ldN && allSel && weN) |=> (s1Valid && !s1Write)); // R3
  AST_ADVANCE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (edgeEn && ldN) |=> (s1Addr[1:0] == $past(s1Addr[1:0]) + 2'd1)); // R11
  AST_ADVANCE_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    (edgeEn && ldN) |=> ($stable(s1Valid) && $stable(s1Write))); // R11
endmodule

// File: rtl/sram_datapath.sv
`timescale 1ns/1ps
module sram_datapath
  import sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sram_strobe_t            stb,
  input  logic [AW-1:0]           rdAddr,
  input  logic [AW-1:0]           wrAddr,
  input  logic [LANES-1:0]        byteWeN,
  input  logic [LANES*LANE_W-1:0] dqIn,
  input  logic                    oeN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqOe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] readWord;
  logic [DW-1:0] doutReg;
  logic          outActive;
  logic          sameAddr;

  assign sameAddr = stb.wrCommit && (wrAddr == rdAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (stb.en && stb.wrCommit && !byteWeN[g])
        laneMem[wrAddr] <= dqIn[g*LANE_W +: LANE_W];
    end

    // late-write bypass: lane being committed this edge wins
    assign readWord[g*LANE_W +: LANE_W] =
      (sameAddr && !byteWeN[g]) ? dqIn[g*LANE_W +: LANE_W] : laneMem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outActive <= 1'b0;
      doutReg   <= '0;
    end else if (stb.en) begin
      outActive <= stb.rdLoad;
      if (stb.rdLoad)
        doutReg <= readWord;
    end
  end

  assign dqOut = doutReg;
  assign dqOe  = outActive && !oeN && !sleep;

  AST_WRITE_FLOATS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCommit |-> !outActive); // R6
  AST_OUT_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.en |=> ($stable(outActive) && $stable(doutReg))); // R1
  AST_NO_DRIVE_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rstN)
    (stb.en && !stb.rdLoad) |=> !outActive); // R5
endmodule

// File: rtl/pipelined_sram.sv
`timescale 1ns/1ps
module pipelined_sram
  import sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    selAN,
  input  logic                    selB,
  input  logic                    selCN,
  input  logic                    ldN,
  input  logic                    weN,
  input  logic [LANES-1:0]        byteWeN,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] dqIn,
  input  logic                    oeN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqOe
);
  sram_strobe_t  stb;
  logic [AW-1:0] rdAddr;
  logic [AW-1:0] wrAddr;

  sram_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep),
    .selAN(selAN), .selB(selB), .selCN(selCN), .ldN(ldN), .weN(weN),
    .addr(addr), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr)
  );

  sram_datapath #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .byteWeN(byteWeN), .dqIn(dqIn), .oeN(oeN), .sleep(sleep),
    .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: tb/pipelined_sram_tb.sv
`timescale 1ns/1ps
module pipelined_sram_tb;
  localparam int LANES = 4, LANE_W = 9, AW = 8, DW = LANES * LANE_W;

  logic clk = 1'b0, rstN = 1'b0, clkEnN = 1'b0;
  logic selAN = 1'b1, selB = 1'b0, selCN = 1'b1;
  logic ldN = 1'b0, weN = 1'b1, oeN = 1'b0, sleep = 1'b0;
  logic [LANES-1:0] byteWeN = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dqIn = '0;
  logic [DW-1:0] dqOut;
  logic dqOe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pipelined_sram #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selAN(selAN), .selB(selB),
    .selCN(selCN), .ldN(ldN), .weN(weN), .byteWeN(byteWeN), .addr(addr),
    .dqIn(dqIn), .oeN(oeN), .sleep(sleep), .dqOut(dqOut), .dqOe(dqOe)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // ld: load new command; sel: all selects active; we: write
  task automatic step(input logic ld, input logic sel, input logic we, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic [LANES-1:0] wbe);
    ldN = !ld; selAN = !sel; selB = sel; selCN = !sel; weN = !we;
    addr = a; dqIn = wd; byteWeN = wbe;
    @(posedge clk); #1;
  endtask

  task automatic nop();
    step(1'b1, 1'b0, 1'b0, '0, '0, '1);
  endtask

  task automatic writeWord(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LANES-1:0] be);
    step(1'b1, 1'b1, 1'b1, a, '0, '1);
    nop();
    step(1'b1, 1'b0, 1'b0, '0, d, be);
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [LANES-1:0] beN);
    logic [DW-1:0] r = old;
    for (int i = 0; i < LANES; i++)
      if (!beN[i]) r[i*LANE_W +: LANE_W] = nw[i*LANE_W +: LANE_W];
    return r;
  endfunction

  task automatic readCheck(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    step(1'b1, 1'b1, 1'b0, a, '0, '1);
    nop();
    check({req, " drive"}, DW'(dqOe), DW'(1'b1));
    check({req, " data"}, dqOut, exp);
  endtask

  task automatic testReset();
    check("R12 no drive after reset", DW'(dqOe), '0);
    nop();
    check("R12 still idle", DW'(dqOe), '0);
  endtask

  task automatic testWriteRead();
    step(1'b1, 1'b1, 1'b1, 8'd5, '0, '1);
    check("R6 no drive after write edge", DW'(dqOe), '0);
    nop();
    step(1'b1, 1'b0, 1'b0, '0, 36'h123456789, '0);
    readCheck("R3 R6 read back", 8'd5, 36'h123456789);
    nop();
    check("R2 deselect stops drive", DW'(dqOe), '0);
  endtask

  task automatic testBackToBack();
    writeWord(8'd11, 36'h0F0F0F0F0, '0);
    step(1'b1, 1'b1, 1'b1, 8'd10, '0, '1);             // E0 write 10
    check("R6 write cycle floats even with oeN low", DW'(dqOe), '0);
    step(1'b1, 1'b1, 1'b0, 8'd5, '0, '1);              // E1 read 5
    step(1'b1, 1'b1, 1'b0, 8'd11, 36'hABCDEF012, '0);  // E2 read 11, data for 10
    check("R4 read 5 after write", dqOut, 36'h123456789);
    check("R4 drive", DW'(dqOe), DW'(1'b1));
    step(1'b1, 1'b1, 1'b0, 8'd10, '0, '1);             // E3 read 10
    check("R4 read 11", dqOut, 36'h0F0F0F0F0);
    nop();
    check("R4 read 10", dqOut, 36'hABCDEF012);
    nop();
  endtask

  task automatic testDeselectPipe();
    step(1'b1, 1'b1, 1'b0, 8'd5, '0, '1);
    step(1'b1, 1'b0, 1'b0, 8'd0, '0, '1);
    check("R5 still driving after deselect edge", DW'(dqOe), DW'(1'b1));
    check("R5 data", dqOut, 36'h123456789);
    nop();
    check("R5 floats one edge later", DW'(dqOe), '0);
  endtask

  task automatic testOe();
    step(1'b1, 1'b1, 1'b0, 8'd5, '0, '1);
    nop();
    oeN = 1'b1; #1;
    check("R8 oeN high drops drive", DW'(dqOe), '0);
    oeN = 1'b0; #1;
    check("R8 oeN low restores drive", DW'(dqOe), DW'(1'b1));
    nop();
  endtask

  task automatic testClockHold();
    step(1'b1, 1'b1, 1'b0, 8'd5, '0, '1);
    clkEnN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 1'b0, 8'd10, '0, '1);
      check("R1 held, no output yet", DW'(dqOe), '0);
    end
    clkEnN = 1'b0;
    nop();
    check("R1 held read resumes", dqOut, 36'h123456789);
    check("R1 drive", DW'(dqOe), DW'(1'b1));
    clkEnN = 1'b1;
    step(1'b1, 1'b1, 1'b1, 8'd10, '0, '1);
    step(1'b1, 1'b1, 1'b1, 8'd10, '0, '0);
    check("R1 output register held", dqOut, 36'h123456789);
    check("R1 drive held", DW'(dqOe), DW'(1'b1));
    clkEnN = 1'b0;
    nop();
    check("R1 ignored read did not run", DW'(dqOe), '0);
    readCheck("R1 word 10 untouched", 8'd10, 36'hABCDEF012);
    nop();
  endtask

  task automatic testLanes();
    writeWord(8'd30, 36'h111111111, '0);
    writeWord(8'd30, 36'hFFFFFFFFF, 4'b1010);
    readCheck("R7 lanes 0,2 written", 8'd30, merge(36'h111111111, 36'hFFFFFFFFF, 4'b1010));
    nop();
  endtask

  task automatic testBypass();
    step(1'b1, 1'b1, 1'b1, 8'd20, '0, '1);
    step(1'b1, 1'b1, 1'b0, 8'd20, '0, '1);
    step(1'b1, 1'b0, 1'b0, '0, 36'h987654321, '0);
    check("R10 full bypass", dqOut, 36'h987654321);
    writeWord(8'd21, 36'h222222222, '0);
    step(1'b1, 1'b1, 1'b1, 8'd21, '0, '1);
    step(1'b1, 1'b1, 1'b0, 8'd21, '0, '1);
    step(1'b1, 1'b0, 1'b0, '0, 36'h000000000, 4'b0101);
    check("R10 partial bypass", dqOut, merge(36'h222222222, 36'h0, 4'b0101));
    nop();
  endtask

  task automatic testSleep();
    step(1'b1, 1'b1, 1'b0, 8'd5, '0, '1);
    sleep = 1'b1; #1;
    check("R9 sleep forces no drive", DW'(dqOe), '0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 1'b1, 8'd5, 36'hDEADBEEF0, '0);
      check("R9 no drive while asleep", DW'(dqOe), '0);
    end
    sleep = 1'b0;
    nop();
    nop();
    readCheck("R9 contents preserved", 8'd5, 36'h123456789);
    nop();
  endtask

  task automatic testAdvance();
    writeWord(8'h40, 36'h000000040, '0);
    writeWord(8'h41, 36'h000000041, '0);
    writeWord(8'h43, 36'h000000043, '0);
    step(1'b1, 1'b1, 1'b0, 8'h43, '0, '1);
    step(1'b0, 1'b0, 1'b1, 8'h00, '0, '1);  // advance; selects and weN ignored
    check("R11 first word", dqOut, 36'h000000043);
    step(1'b0, 1'b0, 1'b1, 8'h00, '0, '1);
    check("R11 wraps to group start", dqOut, 36'h000000040);
    nop();
    check("R11 next in group", dqOut, 36'h000000041);
    step(1'b0, 1'b1, 1'b0, 8'h40, '0, '1);
    check("R11 deselect stays off", DW'(dqOe), '0);
    nop();
    check("R11 still deselected", DW'(dqOe), '0);
  endtask

  initial begin
    @(posedge clk); #1;
    @(posedge clk); #1;
    rstN = 1'b1;
    testReset();
    testWriteRead();
    testBackToBack();
    testDeselectPipe();
    testOe();
    testClockHold();
    testLanes();
    testBypass();
    testSleep();
    testAdvance();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule